// File: doc/BRIEF.md
# Timer PWM Trigger Output

This block produces the level of a timer's output pin from the overflow and match strobes that a neighbouring counter supplies. Each qualifying event either inverts the pin or pulses it for one clock. A programmed default level is applied whenever the counter is halted, and also whenever the control register is rewritten with triggering switched off. Counting, match detection and capture are done elsewhere. This block only turns their single-cycle strobes into the pin waveform.

The pin level is registered, so any input change shows on `pwm_o` at the next rising clock edge. When the pin is configured as an input, the block keeps its last level and ignores every other input.

Top module: `pwm_trig_out`

## Requirements
- R1: While `rst_n` is low, `pwm_o` is 0. It stays 0 after reset is released until an update rule changes it.
- R2: The trigger mode uses this encoding: 0 = no trigger, 1 = overflow only, 2 = overflow or match, 3 = treated as no trigger. In mode 1, a match strobe without an overflow strobe is not an event.
- R3: In mode 2, a match strobe on its own is an event, and so is an overflow strobe on its own.
- R4: Toggle select is 1 when `toggle_i` = 1. In that case, an event in cycle N makes `pwm_o` after edge N the inverse of its previous value, and without an event the level holds.
- R5: Pulse select is 0 when `toggle_i` = 0. In that case, an event in cycle N drives `pwm_o` to the inverse of `dflt_i` for that one cycle. In any running cycle with no event, `pwm_o` goes to `dflt_i`.
- R6: In mode 2, an overflow and a match in the same cycle count as a single event, so the pin toggles once or pulses once.
- R7: When the counter is running and `ctrl_wr_i` is high with mode 0 or 3, `pwm_o` becomes `dflt_i` at the next edge.
- R8: When `run_i` is 0 and the pin is an output, `pwm_o` becomes `dflt_i` at the next edge. This rule takes priority over all events and writes.
- R9: When `dir_in_i` = 1 (pin is an input), `pwm_o` holds its value whatever the other inputs do.
- R10: When the counter is running in mode 0 or 3 and there is no control write, `pwm_o` holds, and strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovf_i | input | 1 | Counter overflow strobe, one cycle |
| mat_i | input | 1 | Compare match strobe, one cycle |
| run_i | input | 1 | Counter running flag |
| trig_mode_i | input | 2 | Trigger mode: 0 none, 1 overflow, 2 overflow or match, 3 none |
| toggle_i | input | 1 | 1 = toggle on event, 0 = one-cycle pulse |
| dflt_i | input | 1 | Default pin level |
| dir_in_i | input | 1 | 1 = pin configured as input, no update |
| ctrl_wr_i | input | 1 | Control register write strobe |
| pwm_o | output | 1 | Registered pin level |

## Verification
The bench targets the following corner cases:
- **Coincident strobes in mode 2.** A design that counts each strobe separately would toggle twice in one cycle, which leaves the pin unchanged.
- **Match-only cycles in mode 1, and strobes in mode 3.** A careless decoder would treat these as events and move the pin.
- **Priority between a halted counter, a control write and an input-direction pin.** If the order is wrong, the default level is forced onto a pin that should hold, or it is missed when the counter stops.
- **Pulse mode returning to the default level after one cycle.** A design that latches the pulse would leave the pin stuck at the inverted level.

// File: rtl/pwm_trig_pkg.sv
package pwm_trig_pkg;

    typedef enum logic [1:0] {
        TRG_OFF  = 2'd0,
        TRG_OVF  = 2'd1,
        TRG_BOTH = 2'd2,
        TRG_RSVD = 2'd3
    } trig_mode_e;

    typedef struct packed {
        logic pwm;
    } pwm_state_t;

    // Mode 0 and the reserved code both mean "no triggering".
    function automatic logic mode_is_idle(trig_mode_e m);
        return (m == TRG_OFF) || (m == TRG_RSVD);
    endfunction

endpackage

// File: rtl/pwm_event_sel.sv
module pwm_event_sel
    import pwm_trig_pkg::*;
(
    input  logic       ovf_i,
    input  logic       mat_i,
    input  trig_mode_e mode_i,
    output logic       evt_o
);
    // Merging both strobes into one flag makes coincident events count once.
    always_comb begin
        unique case (mode_i)
            TRG_OVF:  evt_o = ovf_i;
            TRG_BOTH: evt_o = ovf_i | mat_i;
            default:  evt_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_level_next.sv
module pwm_level_next (
    input  logic cur_i,
    input  logic evt_i,
    input  logic toggle_i,
    input  logic dflt_i,
    output logic lvl_o
);
    always_comb begin
        if (toggle_i) begin
            lvl_o = evt_i ? ~cur_i : cur_i;
        end else begin
            lvl_o = evt_i ? ~dflt_i : dflt_i;
        end
    end
endmodule

// File: rtl/pwm_trig_out.sv
module pwm_trig_out
    import pwm_trig_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_i,
    input  logic       mat_i,
    input  logic       run_i,
    input  logic [1:0] trig_mode_i,
    input  logic       toggle_i,
    input  logic       dflt_i,
    input  logic       dir_in_i,
    input  logic       ctrl_wr_i,
    output logic       pwm_o
);
    trig_mode_e mode;
    logic       evt;
    logic       lvl_nxt;
    logic       idle;
    pwm_state_t st_d, st_q;

    assign mode = trig_mode_e'(trig_mode_i);
    assign idle = mode_is_idle(mode);

    pwm_event_sel u_evt (
        .ovf_i  (ovf_i),
        .mat_i  (mat_i),
        .mode_i (mode),
        .evt_o  (evt)
    );

    pwm_level_next u_lvl (
        .cur_i    (st_q.pwm),
        .evt_i    (evt),
        .toggle_i (toggle_i),
        .dflt_i   (dflt_i),
        .lvl_o    (lvl_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (!dir_in_i) begin
            if (!run_i) begin
                st_d.pwm = dflt_i;
            end else if (ctrl_wr_i && idle) begin
                st_d.pwm = dflt_i;
            end else if (!idle) begin
                st_d.pwm = lvl_nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pwm <= RESET_LEVEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.pwm;

endmodule

// File: rtl/pwm_trig_out_chk.sv
module pwm_trig_out_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ovf_i,
    input logic       mat_i,
    input logic       run_i,
    input logic [1:0] trig_mode_i,
    input logic       toggle_i,
    input logic       dflt_i,
    input logic       dir_in_i,
    input logic       ctrl_wr_i,
    input logic       pwm_o
);
    logic act;
    logic quiet_mode;
    logic ev;

    assign act        = run_i && !dir_in_i;
    assign quiet_mode = (trig_mode_i == 2'd0) || (trig_mode_i == 2'd3);
    assign ev         = ((trig_mode_i == 2'd1) && ovf_i) ||
                        ((trig_mode_i == 2'd2) && (ovf_i || mat_i));

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_low_chk: assert (pwm_o == 1'b0);
        end
    end

    // R4
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act && toggle_i && ev |=> pwm_o != $past(pwm_o));

    // R5
    pulse_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act && !toggle_i && !quiet_mode |=> pwm_o == ($past(ev) ? !$past(dflt_i) : $past(dflt_i)));

    // R7
    wr_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act && ctrl_wr_i && quiet_mode |=> pwm_o == $past(dflt_i));

    // R8
    stop_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i && !dir_in_i |=> pwm_o == $past(dflt_i));

    // R9
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_in_i |=> $stable(pwm_o));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act && quiet_mode && !ctrl_wr_i |=> $stable(pwm_o));

    // R2
    mat_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act && toggle_i && (trig_mode_i == 2'd1) && !ovf_i |=> $stable(pwm_o));

endmodule

bind pwm_trig_out pwm_trig_out_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovf_i       (ovf_i),
    .mat_i       (mat_i),
    .run_i       (run_i),
    .trig_mode_i (trig_mode_i),
    .toggle_i    (toggle_i),
    .dflt_i      (dflt_i),
    .dir_in_i    (dir_in_i),
    .ctrl_wr_i   (ctrl_wr_i),
    .pwm_o       (pwm_o)
);

// File: tb/pwm_trig_out_test.sv
module pwm_trig_out_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ovf_i = 1'b0, mat_i = 1'b0, run_i = 1'b0;
    logic [1:0] trig_mode_i = 2'd0;
    logic       toggle_i = 1'b0, dflt_i = 1'b0, dir_in_i = 1'b0, ctrl_wr_i = 1'b0;
    logic       pwm_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    logic exp_q = 1'b0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_trig_out uut (
        .clk(clk), .rst_n(rst_n), .ovf_i(ovf_i), .mat_i(mat_i), .run_i(run_i),
        .trig_mode_i(trig_mode_i), .toggle_i(toggle_i), .dflt_i(dflt_i),
        .dir_in_i(dir_in_i), .ctrl_wr_i(ctrl_wr_i), .pwm_o(pwm_o)
    );

    // Expected next pin level, written from the requirements.
    function automatic logic model(logic cur, logic run, logic dir, logic wr,
                                   logic [1:0] m, logic ov, logic mt, logic tg, logic df);
        logic hit;
        if (dir) return cur;                           // R9
        if (!run) return df;                           // R8
        if (m == 2'd0 || m == 2'd3) return wr ? df : cur; // R7 / R10
        hit = (m == 2'd1) ? ov : (ov | mt);            // R2 / R3 / R6
        if (tg) return hit ? ~cur : cur;               // R4
        return hit ? ~df : df;                         // R5
    endfunction

    function automatic string tag(logic run, logic dir, logic wr,
                                  logic [1:0] m, logic ov, logic mt, logic tg);
        if (dir) return "R9";
        if (!run) return "R8";
        if (m == 2'd0 || m == 2'd3) return wr ? "R7" : "R10";
        if (m == 2'd2 && ov && mt) return "R6";
        if (m == 2'd2 && mt && !ov) return "R3";
        if (m == 2'd1 && mt && !ov) return "R2";
        return tg ? "R4" : "R5";
    endfunction

    task automatic check(string req, logic act, logic expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: pwm_o=%0b expected=%0b at %0t", req, act, expv, $time);
        end
    endtask

    // Called at a falling edge: apply inputs, then check after the next rise.
    task automatic step(logic run, logic dir, logic wr, logic [1:0] m,
                        logic ov, logic mt, logic tg, logic df);
        string t;
        run_i = run; dir_in_i = dir; ctrl_wr_i = wr; trig_mode_i = m;
        ovf_i = ov; mat_i = mt; toggle_i = tg; dflt_i = df;
        exp_q = model(exp_q, run, dir, wr, m, ov, mt, tg, df);
        t = tag(run, dir, wr, m, ov, mt, tg);
        @(negedge clk);
        check(t, pwm_o, exp_q);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0a17));
        repeat (3) @(negedge clk);
        check("R1", pwm_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", pwm_o, 1'b0);
        exp_q = 1'b0;

        // Directed corner cases
        step(1, 0, 0, 2'd1, 0, 0, 1, 0);   // R4 hold, no event
        step(1, 0, 0, 2'd1, 1, 0, 1, 0);   // R4 toggle to 1
        step(1, 0, 0, 2'd1, 0, 1, 1, 0);   // R2 match ignored
        step(1, 0, 0, 2'd2, 0, 1, 1, 0);   // R3 match toggles
        step(1, 0, 0, 2'd2, 1, 1, 1, 0);   // R6 coincident once
        step(1, 0, 0, 2'd2, 1, 1, 1, 0);   // R6 again
        step(1, 0, 0, 2'd3, 1, 1, 1, 0);   // R10 reserved ignores
        step(1, 0, 1, 2'd3, 0, 0, 1, 1);   // R7 write none -> default 1
        step(1, 0, 0, 2'd0, 1, 0, 1, 0);   // R10 hold at 1
        step(1, 0, 0, 2'd1, 1, 0, 0, 0);   // R5 pulse high
        step(1, 0, 0, 2'd1, 0, 0, 0, 0);   // R5 back to default
        step(1, 0, 0, 2'd2, 1, 1, 0, 1);   // R6 pulse low once
        step(1, 0, 0, 2'd2, 0, 0, 0, 1);   // R5 back to 1
        step(1, 1, 1, 2'd1, 1, 1, 1, 0);   // R9 input pin holds
        step(0, 1, 0, 2'd1, 0, 0, 1, 0);   // R9 beats stop
        step(0, 0, 1, 2'd2, 1, 1, 1, 0);   // R8 stop forces default 0
        step(0, 0, 0, 2'd1, 1, 0, 1, 1);   // R8 default 1

        for (int i = 0; i < N_RAND; i++) begin
            step(($urandom % 8) != 0, ($urandom % 8) == 0, ($urandom % 6) == 0,
                 2'($urandom % 4), ($urandom % 3) == 0, ($urandom % 3) == 0,
                 1'($urandom % 2), 1'($urandom % 2));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule